// File: doc/BRIEF.md
# Circular Modulo DMA Address Generator

This block produces the address pair for every 32-bit beat of a stream that reads from a power-of-two ring buffer in memory and writes to one peripheral data register. A pulse on the request input starts a minor loop of a programmed number of bytes, issued as 4-byte beats on a valid/ready handshake. Each beat carries a source and a destination address. The source walks forward by a signed step. A modulo width keeps the source inside an aligned window of 2^N bytes by holding every address bit at or above N fixed, so the ring never needs a reload.

A major counter counts finished minor loops. When it expires, the block raises a one-cycle completion interrupt and reloads the counter from its programmed value, so streaming goes on without outside help. A playback position register advances by one whole major loop at each completion and folds back by the ring size when it reaches or passes it. Requests that arrive while a minor loop is still running are remembered and served back-to-back.

Top module: `ring_dma_addr_gen`

## Requirements
- R1: After reset, beat_valid, major_irq and play_pos are 0. Until the first cfg_load, requests cause no beats.
- R2: A cfg_load pulse captures every cfg_* value and resets the position to 0. In the next cycle, beat_src equals cfg_src_start and beat_dst equals cfg_dst_addr.
- R3: A request seen while idle raises beat_valid in the next cycle. One minor loop issues cfg_minor_bytes/4 beats, with the two low bits of the byte count ignored. While beat_ready is low, a beat and its addresses are held.
- R4: After each accepted beat, the source address becomes the old address plus the sign-extended cfg_src_step. With cfg_mod_bits = N > 0, bits N and above stay unchanged and only the low N bits wrap. N = 0 gives a plain 32-bit add.
- R5: After each accepted beat, the destination address adds the sign-extended cfg_dst_step. A step of 0 keeps it on one register.
- R6: In the cycle after the last beat of the cfg_major_count-th minor loop is accepted, major_irq is high for one cycle. The major counter then reloads.
- R7: In the same cycle that major_irq is high, play_pos becomes old + (minor bytes x major count). The ring size 2^N is subtracted once if the sum reaches it. With N = 0, no fold is applied.
- R8: A request during a minor loop, including in the cycle its last beat is accepted, is held pending. The next loop then begins with no idle cycle. Extra requests while one is pending merge into it.
- R9: When a major loop ends, no address adjustment is applied. The next beat continues from where the addresses left off.
- R10: A cfg_load while a loop is running aborts it and clears any pending request. The following cycle shows beat_valid low, the new start addresses and play_pos 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration and (re)start |
| cfg_src_start | input | ADDR_W | First source address |
| cfg_dst_addr | input | ADDR_W | First destination address |
| cfg_src_step | input | STEP_W | Signed source increment per beat |
| cfg_dst_step | input | STEP_W | Signed destination increment per beat |
| cfg_mod_bits | input | MOD_W | Ring size exponent N (0 = no wrap) |
| cfg_minor_bytes | input | MINOR_W | Bytes per minor loop |
| cfg_major_count | input | MAJOR_W | Minor loops per major loop |
| xfer_req | input | 1 | Peripheral request pulse |
| beat_valid | output | 1 | Beat address pair valid |
| beat_ready | input | 1 | Beat accepted by the bus side |
| beat_src | output | ADDR_W | Source address of the current beat |
| beat_dst | output | ADDR_W | Destination address of the current beat |
| major_irq | output | 1 | One-cycle major loop completion pulse |
| play_pos | output | ADDR_W | Playback offset inside the ring |

## Verification
The assertions assume a legal configuration:
- a minor byte count of at least 4;
- a nonzero major count;
- one major loop of bytes no larger than the ring, so the position folds with a single subtraction;
- a step magnitude smaller than the ring.

The stimulus uses a 64-byte ring with 48-byte major loops, a 128 KiB ring crossed at its top edge, and an unwrapped mode whose address overflows past 2^32. Every load keeps within those limits. Requests are issued periodically or held high, and ready is randomized, so stalls, pending merges and back-to-back loops all occur.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [0:0] {
    LOOP_IDLE = 1'b0,
    LOOP_BEAT = 1'b1
  } loop_state_e;
endpackage

// File: rtl/ring_dma_step.sv
module ring_dma_step #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16,
  localparam int MOD_W = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] step,
  input  logic [MOD_W-1:0]  mod_bits,
  output logic [ADDR_W-1:0] addr_nxt
);
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    if (mod_bits == '0) low_mask = '1;
    else                low_mask = (ADDR_W'(1) << mod_bits) - ADDR_W'(1);
    sum      = addr + {{(ADDR_W-STEP_W){step[STEP_W-1]}}, step};
    addr_nxt = (addr & ~low_mask) | (sum & low_mask);
  end
endmodule

// File: rtl/ring_dma_loop_ctrl.sv
module ring_dma_loop_ctrl
  import ring_dma_pkg::*;
#(
  parameter int MINOR_W = 8,
  parameter int MAJOR_W = 16,
  localparam int BEAT_W = MINOR_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [MINOR_W-1:0] minor_bytes,
  input  logic [MAJOR_W-1:0] major_count,
  input  logic               req,
  input  logic               ready,
  output logic               beat_valid,
  output logic               major_done,
  output logic               irq
);
  loop_state_e       state;
  logic              armed;
  logic              pend;
  logic [BEAT_W-1:0]  nb_q, beats_left;
  logic [MAJOR_W-1:0] maj_q, major_left;
  logic              last_beat;

  assign beat_valid = (state == LOOP_BEAT);
  assign last_beat  = beat_valid && ready && (beats_left == BEAT_W'(1));
  assign major_done = last_beat && (major_left == MAJOR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LOOP_IDLE;
      armed      <= 1'b0;
      pend       <= 1'b0;
      nb_q       <= '0;
      maj_q      <= '0;
      beats_left <= '0;
      major_left <= '0;
      irq        <= 1'b0;
    end else if (load) begin
      state      <= LOOP_IDLE;
      armed      <= 1'b1;
      pend       <= 1'b0;
      nb_q       <= minor_bytes[MINOR_W-1:2];
      maj_q      <= major_count;
      beats_left <= minor_bytes[MINOR_W-1:2];
      major_left <= major_count;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (armed) begin
        case (state)
          LOOP_IDLE: begin
            if (req || pend) begin
              state <= LOOP_BEAT;
              pend  <= 1'b0;
            end
          end
          LOOP_BEAT: begin
            if (last_beat) begin
              beats_left <= nb_q;
              if (major_left == MAJOR_W'(1)) begin
                major_left <= maj_q;
                irq        <= 1'b1;
              end else begin
                major_left <= major_left - MAJOR_W'(1);
              end
              state <= (pend || req) ? LOOP_BEAT : LOOP_IDLE;
              pend  <= 1'b0;
            end else begin
              if (ready) beats_left <= beats_left - BEAT_W'(1);
              if (req)   pend <= 1'b1;
            end
          end
          default: state <= LOOP_IDLE;
        endcase
      end
    end
  end

  // R3
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !ready && !load |=> beat_valid);

  // R1
  valid_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> armed);

  // R6
  irq_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(beat_valid && ready && !load));
endmodule

// File: rtl/ring_dma_pos_track.sv
module ring_dma_pos_track #(
  parameter int POS_W = 32,
  parameter int INC_W = 24,
  localparam int MOD_W = $clog2(POS_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [INC_W-1:0] inc,
  input  logic [MOD_W-1:0] mod_bits,
  output logic [POS_W-1:0] pos
);
  logic [POS_W:0] sum;
  logic [POS_W:0] ring_size;

  always_comb begin
    ring_size = (POS_W+1)'(1) << mod_bits;
    sum       = {1'b0, pos} + (POS_W+1)'(inc);
    if (mod_bits != '0 && sum >= ring_size) sum = sum - ring_size;
  end

  always_ff @(posedge clk) begin
    if (rst || load)  pos <= '0;
    else if (advance) pos <= sum[POS_W-1:0];
  end

  // R7
  pos_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    mod_bits != '0 |-> {1'b0, pos} < ring_size);

  // R7
  pos_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !advance && !load |=> $stable(pos));
endmodule

// File: rtl/ring_dma_addr_gen.sv
module ring_dma_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int STEP_W  = 16,
  parameter int MINOR_W = 8,
  parameter int MAJOR_W = 16,
  localparam int MOD_W  = $clog2(ADDR_W),
  localparam int INC_W  = MINOR_W + MAJOR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_load,
  input  logic [ADDR_W-1:0]  cfg_src_start,
  input  logic [ADDR_W-1:0]  cfg_dst_addr,
  input  logic [STEP_W-1:0]  cfg_src_step,
  input  logic [STEP_W-1:0]  cfg_dst_step,
  input  logic [MOD_W-1:0]   cfg_mod_bits,
  input  logic [MINOR_W-1:0] cfg_minor_bytes,
  input  logic [MAJOR_W-1:0] cfg_major_count,
  input  logic               xfer_req,
  output logic               beat_valid,
  input  logic               beat_ready,
  output logic [ADDR_W-1:0]  beat_src,
  output logic [ADDR_W-1:0]  beat_dst,
  output logic               major_irq,
  output logic [ADDR_W-1:0]  play_pos
);
  logic [STEP_W-1:0] src_step_q, dst_step_q;
  logic [MOD_W-1:0]  mod_q;
  logic [INC_W-1:0]  inc_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic              major_done;
  logic              fire;
  logic [ADDR_W-1:0] hi_mask;

  assign fire = beat_valid && beat_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_step_q <= '0;
      dst_step_q <= '0;
      mod_q      <= '0;
      inc_q      <= '0;
      src_q      <= '0;
      dst_q      <= '0;
    end else if (cfg_load) begin
      src_step_q <= cfg_src_step;
      dst_step_q <= cfg_dst_step;
      mod_q      <= cfg_mod_bits;
      inc_q      <= INC_W'({cfg_minor_bytes[MINOR_W-1:2], 2'b00}) * INC_W'(cfg_major_count);
      src_q      <= cfg_src_start;
      dst_q      <= cfg_dst_addr;
    end else if (fire) begin
      src_q <= src_nxt;
      dst_q <= dst_nxt;
    end
  end

  ring_dma_step #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_src_step (
    .addr(src_q), .step(src_step_q), .mod_bits(mod_q), .addr_nxt(src_nxt)
  );

  ring_dma_step #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_dst_step (
    .addr(dst_q), .step(dst_step_q), .mod_bits('0), .addr_nxt(dst_nxt)
  );

  ring_dma_loop_ctrl #(.MINOR_W(MINOR_W), .MAJOR_W(MAJOR_W)) u_loop (
    .clk(clk), .rst(rst), .load(cfg_load),
    .minor_bytes(cfg_minor_bytes), .major_count(cfg_major_count),
    .req(xfer_req), .ready(beat_ready),
    .beat_valid(beat_valid), .major_done(major_done), .irq(major_irq)
  );

  ring_dma_pos_track #(.POS_W(ADDR_W), .INC_W(INC_W)) u_pos (
    .clk(clk), .rst(rst), .load(cfg_load), .advance(major_done),
    .inc(inc_q), .mod_bits(mod_q), .pos(play_pos)
  );

  assign beat_src = src_q;
  assign beat_dst = dst_q;

  always_comb begin
    if (mod_q == '0) hi_mask = '0;
    else             hi_mask = ~((ADDR_W'(1) << mod_q) - ADDR_W'(1));
  end

  // R4
  src_frozen_hi_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !cfg_load |=> ((beat_src ^ $past(beat_src)) & hi_mask) == '0);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_ready && !cfg_load |=> $stable(beat_src) && $stable(beat_dst));
endmodule

// File: tb/test_ring_dma_addr_gen.sv
module test_ring_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_src_start = '0, cfg_dst_addr = '0;
  logic [15:0] cfg_src_step = '0, cfg_dst_step = '0;
  logic [4:0]  cfg_mod_bits = '0;
  logic [7:0]  cfg_minor_bytes = '0;
  logic [15:0] cfg_major_count = '0;
  logic        xfer_req = 1'b0, beat_ready = 1'b0;
  logic        beat_valid, major_irq;
  logic [31:0] beat_src, beat_dst, play_pos;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_dma_addr_gen i_ring_dma_addr_gen (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_src_start(cfg_src_start), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_mod_bits(cfg_mod_bits), .cfg_minor_bytes(cfg_minor_bytes),
    .cfg_major_count(cfg_major_count), .xfer_req(xfer_req),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_src(beat_src), .beat_dst(beat_dst),
    .major_irq(major_irq), .play_pos(play_pos)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_valid, m_pend, m_armed, m_irq;
  longint      m_pos;
  logic [31:0] m_src, m_dst;
  int          m_beats, m_major;
  int          mc_step, mc_dstep, mc_mod, mc_nb, mc_maj;
  longint      mc_inc;

  function automatic logic [31:0] m_wrap(logic [31:0] a, int st, int md);
    longint unsigned size, lo, hi;
    size = (md == 0) ? 64'h1_0000_0000 : (64'd1 << md);
    lo = longint'(a) % size;
    hi = longint'(a) - lo;
    lo = (lo + longint'(st) + size) % size;
    return 32'(hi + lo);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_pend = 0; m_armed = 0; m_irq = 0; m_pos = 0;
      m_src = '0; m_dst = '0; m_beats = 0; m_major = 0;
    end else begin
      m_irq = 0;
      if (cfg_load) begin
        mc_step  = int'($signed(cfg_src_step));
        mc_dstep = int'($signed(cfg_dst_step));
        mc_mod   = int'(cfg_mod_bits);
        mc_nb    = int'(cfg_minor_bytes) / 4;
        mc_maj   = int'(cfg_major_count);
        mc_inc   = longint'(mc_nb) * 4 * mc_maj;
        m_src = cfg_src_start; m_dst = cfg_dst_addr;
        m_beats = mc_nb; m_major = mc_maj; m_pos = 0;
        m_valid = 0; m_pend = 0; m_armed = 1;
      end else if (m_armed) begin
        if (m_valid) begin
          if (beat_ready) begin
            m_src = m_wrap(m_src, mc_step, mc_mod);
            m_dst = m_dst + 32'(mc_dstep);
            if (m_beats == 1) begin
              m_beats = mc_nb;
              if (m_major == 1) begin
                m_major = mc_maj;
                m_irq = 1;
                m_pos = m_pos + mc_inc;
                if (mc_mod != 0 && m_pos >= (64'd1 << mc_mod)) m_pos = m_pos - (64'd1 << mc_mod);
                m_pos = m_pos & 64'hFFFF_FFFF;
              end else m_major = m_major - 1;
              m_valid = m_pend || xfer_req;
              m_pend = 0;
            end else begin
              m_beats = m_beats - 1;
              if (xfer_req) m_pend = 1;
            end
          end else if (xfer_req) m_pend = 1;
        end else if (xfer_req || m_pend) begin
          m_valid = 1; m_pend = 0;
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(beat_valid == m_valid, "R3/R8", "beat_valid", beat_valid, m_valid);
      check(beat_src == m_src, "R4/R9", "beat_src", beat_src, m_src);
      check(beat_dst == m_dst, "R5", "beat_dst", beat_dst, m_dst);
      check(major_irq == m_irq, "R6", "major_irq", major_irq, m_irq);
      check(longint'(play_pos) == m_pos, "R7", "play_pos", play_pos, m_pos);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic load_cfg(input logic [31:0] s, input logic [31:0] d,
                          input int ss, input int ds, input int md,
                          input int mb, input int mj);
    @(negedge clk);
    cfg_src_start = s; cfg_dst_addr = d;
    cfg_src_step = 16'(ss); cfg_dst_step = 16'(ds);
    cfg_mod_bits = 5'(md); cfg_minor_bytes = 8'(mb); cfg_major_count = 16'(mj);
    cfg_load = 1'b1; xfer_req = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    int irqs, cyc, gaps;
    bit started;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(beat_valid == 0, "R1", "reset valid", beat_valid, 0);
    check(major_irq == 0, "R1", "reset irq", major_irq, 0);
    check(play_pos == 0, "R1", "reset pos", play_pos, 0);
    // R1 requests before any load
    xfer_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(beat_valid == 0, "R1", "unarmed request", beat_valid, 0);
    end
    xfer_req = 1'b0;

    // 64-byte ring, 16-byte minor loops, 3 per major
    load_cfg(32'h1000_0030, 32'h4000_0020, 4, 0, 6, 16, 3);
    check(beat_src == 32'h1000_0030, "R2", "start src", beat_src, 32'h1000_0030);
    check(beat_dst == 32'h4000_0020, "R2", "start dst", beat_dst, 32'h4000_0020);
    check(beat_valid == 0, "R2", "idle after load", beat_valid, 0);
    irqs = 0; cyc = 0;
    while (irqs < 4) begin
      xfer_req = (cyc % 5 == 0);
      beat_ready = ($urandom_range(0, 3) != 0);
      @(negedge clk);
      cyc++;
      if (major_irq) begin
        irqs++;
        if (irqs == 1) check(play_pos == 48, "R7", "pos first major", play_pos, 48);
        if (irqs == 2) check(play_pos == 32, "R7", "pos folded", play_pos, 32);
        if (irqs == 4) check(play_pos == 0, "R7", "pos exact fold", play_pos, 0);
        check(beat_dst == 32'h4000_0020, "R5", "fixed dst", beat_dst, 32'h4000_0020);
      end
    end
    xfer_req = 1'b0; beat_ready = 1'b1;
    repeat (30) @(negedge clk);

    // 128 KiB ring crossed at its top, requests held high
    load_cfg(32'h2003_FFC0, 32'h4000_0020, 4, 0, 17, 64, 2);
    xfer_req = 1'b1; beat_ready = 1'b1;
    started = 0; gaps = 0;
    do begin
      @(negedge clk);
      if (beat_valid) started = 1;
      else if (started) gaps++;
    end while (!major_irq);
    check(gaps == 0, "R8", "idle gaps between loops", gaps, 0);
    check(beat_src == 32'h2002_0040, "R4", "wrapped src", beat_src, 32'h2002_0040);
    check(play_pos == 128, "R7", "pos no fold", play_pos, 128);
    repeat (20) @(negedge clk);
    check(beat_valid == 1, "R9", "stream continues", beat_valid, 1);

    // No modulo, moving destination, then an abort by reload
    load_cfg(32'hFFFF_FFE8, 32'h0000_1000, 4, 4, 0, 8, 5);
    cyc = 0;
    for (int i = 0; i < 60; i++) begin
      xfer_req = (cyc % 3 == 0);
      beat_ready = ($urandom_range(0, 2) != 0);
      @(negedge clk);
      cyc++;
    end
    xfer_req = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    check(beat_valid == 1, "R10", "busy before abort", beat_valid, 1);
    cfg_src_start = 32'h0000_8000; cfg_dst_addr = 32'h0000_2000;
    cfg_load = 1'b1; xfer_req = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
    check(beat_valid == 0, "R10", "aborted valid", beat_valid, 0);
    check(beat_src == 32'h0000_8000, "R10", "restart src", beat_src, 32'h0000_8000);
    check(play_pos == 0, "R10", "restart pos", play_pos, 0);
    for (int i = 0; i < 60; i++) begin
      xfer_req = (i % 4 == 0);
      beat_ready = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule